// File: doc/BRIEF.md
# I2C Master Register and Interrupt Unit

This block is the byte-wide register file of a small I2C master controller. A host reads and writes single bytes at offsets inside an 18-byte window. The block holds the master and slave address bytes, the control, mode, status, extended status, clock divider, interrupt mask, transfer count, extended control and direct-line registers. Each register applies its own write rule. Some registers store masked bits. Others clear only the bits written as one. Offset 0 is not held here. Strobes at that offset are passed on to a separate data buffer, and that buffer's read byte is returned to the host.

The transfer sequencer reports its events through single-cycle pulses: a transfer finished, a transfer halted, and a transfer error. It also reports whether the bus is busy, and the buffer reports whether it is full and whether it holds data. The block turns the completion and halt events into one registered, level-sensitive interrupt. A source reaches the interrupt only when its mask bit and the global enable in the mode register are both set. Writing a one to bit 0 at offset 15 performs a soft reset. The soft reset restores the same values as the hardware reset and leaves the four address bytes as they were.

Top module: `i2cm_reg_unit`

## Requirements
- R1: After reset, offsets 6, 7, 8, 12, 13, 14 and 15 read 0x00 while the buffer inputs are low. Offset 9 reads 0x40 while the bus is free, offset 16 reads 0x0F, and the interrupt output is low.
- R2: The address bytes at offsets 4, 5, 10 and 11 keep their values through both the hardware reset and the soft reset. `madr_o` presents offset 5 in bits 15:8 and offset 4 in bits 7:0.
- R3: A write to offset 7 (mode) stores the written byte ANDed with 0x3D. Mode bit 2 is the global interrupt enable.
- R4: Status (offset 8) reads as follows: bit 1 is interrupt active, bit 2 is error, bit 4 follows `buf_full_i` and bit 5 follows `buf_avail_i`. Each `evt_err_i` pulse sets bit 2. A write to offset 8 clears only the bits set in both the written byte and 0x0A, so bit 2 survives such a write.
- R5: A status write with bit 1 set deasserts `irq_o` one cycle later when mode bit 2 is set. When mode bit 2 is clear, the same write leaves `irq_o` unchanged.
- R6: Offset 9 reads bits 6:4 as 101 while `bus_busy_i` is high and 100 while it is low. Bit 0 is set by `evt_err_i`. A write to offset 9 clears the stored bits that are set in both the written byte and 0x8F.
- R7: A write to offset 14 stores the byte ANDed with 0x77. A write to offset 16 stores the byte ANDed with 0x0F. Offsets 6 and 12 store the whole byte, which is presented on `ctl_o` and `clkdiv_o`.
- R8: Interrupt mask bit 0 enables the `evt_done_i` source and mask bit 3 enables the `evt_halt_i` source (offset 13). When an enabled source pulses while mode bit 2 is set, `irq_o` rises and status bit 1 sets on the next clock. Otherwise neither changes.
- R9: When an interrupt source fires in the same cycle as a clearing status write, the set wins. `irq_o` and status bit 1 stay set.
- R10: A write to offset 15 with bit 0 set restores every R1 value on the next clock, including `irq_o` low and the error bits cleared. Offset 15 bits 7:4 are cleared when written as one.
- R11: Offsets 1, 2, 3 and every offset from 17 upward read 0x00, and writes to them change no register.
- R12: At offset 0 the block drives `buf_rd_o` on a read and `buf_wr_o` on a write, and returns `buf_rdata_i` on `reg_rdata`. At any other offset neither strobe is driven.
- R13: Read data is combinational from the stored values. A write takes effect at the clock edge that samples it, so data read in the same cycle as the write still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 8 | Write byte |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read byte |
| buf_wr_o | output | 1 | Write strobe to the data buffer |
| buf_rd_o | output | 1 | Read strobe to the data buffer |
| buf_rdata_i | input | 8 | Byte from the data buffer |
| buf_full_i | input | 1 | Data buffer full |
| buf_avail_i | input | 1 | Data buffer holds at least one byte |
| bus_busy_i | input | 1 | I2C bus is busy |
| evt_done_i | input | 1 | Transfer-complete event pulse |
| evt_halt_i | input | 1 | Halt event pulse |
| evt_err_i | input | 1 | Transfer-error event pulse |
| ctl_o | output | 8 | Control register value |
| madr_o | output | 16 | Master address bytes {high, low} |
| clkdiv_o | output | 8 | Clock divider value |
| dirctl_o | output | 8 | Direct-line control value |
| irq_o | output | 1 | Level interrupt |

## Verification
The interrupt path is driven with each source under each mask setting, with the global enable both set and clear. This separates a source that is gated correctly from one that ignores its mask bit or the enable. Status writes are issued with the enable both on and off, and once in the same cycle as a firing source. These cases distinguish the clear rule from the set-wins rule. Masked writes of 0xFF expose any wrong write mask. A status write of 0xFF with the error bit set shows whether the clear mask is too wide. Writes to gaps in the map, a soft reset and a hardware reset after the address bytes are loaded separate "ignored" from "reset" from "retained".

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int NUM_OFS = 17;
  localparam int WINDOW  = 18;

  localparam int OFS_BUF     = 0;
  localparam int OFS_MADR_LO = 4;
  localparam int OFS_MADR_HI = 5;
  localparam int OFS_CTL     = 6;
  localparam int OFS_MODE    = 7;
  localparam int OFS_STAT    = 8;
  localparam int OFS_XSTAT   = 9;
  localparam int OFS_SADR_LO = 10;
  localparam int OFS_SADR_HI = 11;
  localparam int OFS_CDIV    = 12;
  localparam int OFS_IMASK   = 13;
  localparam int OFS_XCNT    = 14;
  localparam int OFS_XCTL    = 15;
  localparam int OFS_DIRCTL  = 16;

  // one bit per offset below NUM_OFS that holds a register (offset 0 included)
  localparam logic [NUM_OFS-1:0] IMPL_MAP = 17'h1FFF1;

  localparam logic [7:0] MODE_WMASK    = 8'h3D;
  localparam logic [7:0] STAT_CLRMASK  = 8'h0A;
  localparam logic [7:0] XSTAT_CLRMASK = 8'h8F;
  localparam logic [7:0] XCNT_WMASK    = 8'h77;
  localparam logic [7:0] XCTL_CLRMASK  = 8'hF0;
  localparam logic [7:0] DIR_WMASK     = 8'h0F;
  localparam logic [7:0] DIR_RESET     = 8'h0F;
  localparam logic [7:0] XSTAT_FREE    = 8'h40;
  localparam logic [7:0] XSTAT_BUSY    = 8'h50;

  localparam int MODE_GEN_BIT   = 2;
  localparam int STAT_IRQ_BIT   = 1;
  localparam int STAT_ERR_BIT   = 2;
  localparam int STAT_FULL_BIT  = 4;
  localparam int STAT_AVAIL_BIT = 5;
  localparam int XSTAT_ERR_BIT  = 0;
  localparam int IMASK_DONE_BIT = 0;
  localparam int IMASK_HALT_BIT = 3;
  localparam int XCTL_SRST_BIT  = 0;
endpackage

// File: rtl/i2cm_dec.sv
module i2cm_dec
  import i2cm_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [NUM_OFS-1:0] sel_o
);
  for (genvar g = 0; g < NUM_OFS; g++) begin : g_sel
    if (IMPL_MAP[g]) begin : g_hit
      assign sel_o[g] = (addr_i == ADDR_W'(g));
    end else begin : g_gap
      assign sel_o[g] = 1'b0;
    end
  end
endmodule

// File: rtl/i2cm_irq.sv
module i2cm_irq
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       soft_rst_i,
  input  logic       gen_i,
  input  logic [7:0] imask_i,
  input  logic       evt_done_i,
  input  logic       evt_halt_i,
  input  logic       clr_i,
  output logic       fire_o,
  output logic       irq_o
);
  assign fire_o = gen_i & ((evt_done_i & imask_i[IMASK_DONE_BIT]) |
                           (evt_halt_i & imask_i[IMASK_HALT_BIT]));

  always_ff @(posedge clk) begin
    if (rst || soft_rst_i)      irq_o <= 1'b0;
    else if (fire_o)            irq_o <= 1'b1;
    else if (clr_i && gen_i)    irq_o <= 1'b0;
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (fire_o && !soft_rst_i) |=> irq_o);

  assert_fall_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_o) |-> $past(soft_rst_i || (clr_i && gen_i)));
endmodule

// File: rtl/i2cm_reg_unit.sv
module i2cm_reg_unit
  import i2cm_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [7:0]        reg_rdata,
  output logic              buf_wr_o,
  output logic              buf_rd_o,
  input  logic [7:0]        buf_rdata_i,
  input  logic              buf_full_i,
  input  logic              buf_avail_i,
  input  logic              bus_busy_i,
  input  logic              evt_done_i,
  input  logic              evt_halt_i,
  input  logic              evt_err_i,
  output logic [7:0]        ctl_o,
  output logic [15:0]       madr_o,
  output logic [7:0]        clkdiv_o,
  output logic [7:0]        dirctl_o,
  output logic              irq_o
);
  localparam int MIN_W = $clog2(WINDOW);

  logic [NUM_OFS-1:0] sel;
  logic [7:0] madr_lo_q, madr_hi_q, sadr_lo_q, sadr_hi_q;
  logic [7:0] ctl_q, mode_q, sts_q, xsts_q, cdiv_q, imask_q, xcnt_q, xctl_q, dir_q;
  logic [7:0] sts_d, xsts_d, xctl_d;
  logic       soft_rst, irq_fire, irq_clr;
  logic [7:0] rvals [NUM_OFS];

  initial if (ADDR_W < MIN_W) $error("ADDR_W too small for the register window");

  i2cm_dec #(.ADDR_W(ADDR_W)) u_dec (.addr_i(reg_addr), .sel_o(sel));

  function automatic logic wen(input logic [NUM_OFS-1:0] s, input int ofs, input logic w);
    return w & s[ofs];
  endfunction

  assign soft_rst = wen(sel, OFS_XCTL, reg_wr) & reg_wdata[XCTL_SRST_BIT];
  assign irq_clr  = wen(sel, OFS_STAT, reg_wr) & reg_wdata[STAT_IRQ_BIT];

  i2cm_irq u_irq (
    .clk(clk), .rst(rst), .soft_rst_i(soft_rst), .gen_i(mode_q[MODE_GEN_BIT]),
    .imask_i(imask_q), .evt_done_i(evt_done_i), .evt_halt_i(evt_halt_i),
    .clr_i(irq_clr), .fire_o(irq_fire), .irq_o(irq_o)
  );

  always_comb begin
    sts_d = sts_q;
    if (wen(sel, OFS_STAT, reg_wr)) sts_d = sts_d & ~(reg_wdata & STAT_CLRMASK);
    if (evt_err_i) sts_d[STAT_ERR_BIT] = 1'b1;
    if (irq_fire)  sts_d[STAT_IRQ_BIT] = 1'b1;

    xsts_d = xsts_q;
    if (wen(sel, OFS_XSTAT, reg_wr)) xsts_d = xsts_d & ~(reg_wdata & XSTAT_CLRMASK);
    if (evt_err_i) xsts_d[XSTAT_ERR_BIT] = 1'b1;

    xctl_d = xctl_q;
    if (wen(sel, OFS_XCTL, reg_wr)) xctl_d = xctl_q & ~(reg_wdata & XCTL_CLRMASK);
  end

  // address bytes: no reset of either kind
  always_ff @(posedge clk) begin
    if (wen(sel, OFS_MADR_LO, reg_wr)) madr_lo_q <= reg_wdata;
    if (wen(sel, OFS_MADR_HI, reg_wr)) madr_hi_q <= reg_wdata;
    if (wen(sel, OFS_SADR_LO, reg_wr)) sadr_lo_q <= reg_wdata;
    if (wen(sel, OFS_SADR_HI, reg_wr)) sadr_hi_q <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      ctl_q   <= '0;
      mode_q  <= '0;
      sts_q   <= '0;
      xsts_q  <= XSTAT_FREE;
      cdiv_q  <= '0;
      imask_q <= '0;
      xcnt_q  <= '0;
      xctl_q  <= '0;
      dir_q   <= DIR_RESET;
    end else begin
      if (wen(sel, OFS_CTL, reg_wr))    ctl_q   <= reg_wdata;
      if (wen(sel, OFS_MODE, reg_wr))   mode_q  <= reg_wdata & MODE_WMASK;
      if (wen(sel, OFS_CDIV, reg_wr))   cdiv_q  <= reg_wdata;
      if (wen(sel, OFS_IMASK, reg_wr))  imask_q <= reg_wdata;
      if (wen(sel, OFS_XCNT, reg_wr))   xcnt_q  <= reg_wdata & XCNT_WMASK;
      if (wen(sel, OFS_DIRCTL, reg_wr)) dir_q   <= reg_wdata & DIR_WMASK;
      sts_q  <= sts_d;
      xsts_q <= xsts_d;
      xctl_q <= xctl_d;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_OFS; i++) rvals[i] = '0;
    rvals[OFS_BUF]     = buf_rdata_i;
    rvals[OFS_MADR_LO] = madr_lo_q;
    rvals[OFS_MADR_HI] = madr_hi_q;
    rvals[OFS_CTL]     = ctl_q;
    rvals[OFS_MODE]    = mode_q;
    rvals[OFS_STAT]    = {2'b00, buf_avail_i, buf_full_i, sts_q[3:0]};
    rvals[OFS_XSTAT]   = (xsts_q & XSTAT_CLRMASK) | (bus_busy_i ? XSTAT_BUSY : XSTAT_FREE);
    rvals[OFS_SADR_LO] = sadr_lo_q;
    rvals[OFS_SADR_HI] = sadr_hi_q;
    rvals[OFS_CDIV]    = cdiv_q;
    rvals[OFS_IMASK]   = imask_q;
    rvals[OFS_XCNT]    = xcnt_q;
    rvals[OFS_XCTL]    = xctl_q;
    rvals[OFS_DIRCTL]  = dir_q;
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_OFS; i++) if (sel[i]) reg_rdata = reg_rdata | rvals[i];
  end

  assign buf_wr_o = wen(sel, OFS_BUF, reg_wr);
  assign buf_rd_o = wen(sel, OFS_BUF, reg_rd);
  assign ctl_o    = ctl_q;
  assign madr_o   = {madr_hi_q, madr_lo_q};
  assign clkdiv_o = cdiv_q;
  assign dirctl_o = dir_q;

  assert_mode_mask_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(OFS_MODE)) |=> (mode_q == ($past(reg_wdata) & 8'h3D)));

  assert_xcnt_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(OFS_XCNT)) |=> (xcnt_q == ($past(reg_wdata) & 8'h77)));

  assert_irq_flag_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> sts_q[STAT_IRQ_BIT]);

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(mode_q[MODE_GEN_BIT]));

  assert_busy_code_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADDR_W'(OFS_XSTAT)) |-> (reg_rdata[6:4] == (bus_busy_i ? 3'b101 : 3'b100)));

  assert_gap_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && (int'(reg_addr) inside {1, 2, 3} || int'(reg_addr) >= NUM_OFS)) |-> (reg_rdata == 8'h00));

  assert_addr_keep_R2: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> $stable({madr_hi_q, madr_lo_q, sadr_hi_q, sadr_lo_q}));
endmodule

// File: tb/i2cm_reg_unit_bench.sv
module i2cm_reg_unit_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic buf_wr_o, buf_rd_o;
  logic [7:0] buf_rdata_i = '0;
  logic buf_full_i = 1'b0, buf_avail_i = 1'b0, bus_busy_i = 1'b0;
  logic evt_done_i = 1'b0, evt_halt_i = 1'b0, evt_err_i = 1'b0;
  logic [7:0] ctl_o, clkdiv_o, dirctl_o;
  logic [15:0] madr_o;
  logic irq_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2cm_reg_unit u_i2cm_reg_unit (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .buf_wr_o(buf_wr_o), .buf_rd_o(buf_rd_o), .buf_rdata_i(buf_rdata_i),
    .buf_full_i(buf_full_i), .buf_avail_i(buf_avail_i), .bus_busy_i(bus_busy_i),
    .evt_done_i(evt_done_i), .evt_halt_i(evt_halt_i), .evt_err_i(evt_err_i),
    .ctl_o(ctl_o), .madr_o(madr_o), .clkdiv_o(clkdiv_o), .dirctl_o(dirctl_o),
    .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b0; reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a; reg_rd = 1'b1;
    #1 check(tag, {8'h00, reg_rdata}, {8'h00, exp});
    @(posedge clk);
    #1 reg_rd = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) evt_done_i = 1'b1;
    else if (which == 1) evt_halt_i = 1'b1;
    else evt_err_i = 1'b1;
    @(posedge clk);
    #1 evt_done_i = 1'b0; evt_halt_i = 1'b0; evt_err_i = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R1 ctl", 5'd6, 8'h00);
    rd_chk("R1 mode", 5'd7, 8'h00);
    rd_chk("R1 status", 5'd8, 8'h00);
    rd_chk("R1 xstatus free", 5'd9, 8'h40);
    rd_chk("R1 clkdiv", 5'd12, 8'h00);
    rd_chk("R1 imask", 5'd13, 8'h00);
    rd_chk("R1 xcnt", 5'd14, 8'h00);
    rd_chk("R1 xctl", 5'd15, 8'h00);
    rd_chk("R1 direct", 5'd16, 8'h0F);
    check("R1 irq", {15'd0, irq_o}, 16'd0);
  endtask

  task automatic t_masks;
    wr(5'd7, 8'hFF);  rd_chk("R3 mode mask", 5'd7, 8'h3D);
    wr(5'd14, 8'hFF); rd_chk("R7 xcnt mask", 5'd14, 8'h77);
    wr(5'd16, 8'hFF); rd_chk("R7 direct mask", 5'd16, 8'h0F);
    check("R7 dirctl_o", {8'h00, dirctl_o}, 16'h000F);
    wr(5'd6, 8'h5A);  check("R7 ctl_o", {8'h00, ctl_o}, 16'h005A);
    wr(5'd12, 8'hA5); check("R7 clkdiv_o", {8'h00, clkdiv_o}, 16'h00A5);
    // R13: same-cycle read shows the old value, next cycle the new one
    @(negedge clk);
    reg_addr = 5'd12; reg_wdata = 8'h3C; reg_wr = 1'b1; reg_rd = 1'b1;
    #1 check("R13 old value during write", {8'h00, reg_rdata}, 16'h00A5);
    @(posedge clk);
    #1 reg_wr = 1'b0;
    check("R13 new value after edge", {8'h00, reg_rdata}, 16'h003C);
    reg_rd = 1'b0;
    wr(5'd7, 8'h00);
  endtask

  task automatic t_buffer;
    buf_rdata_i = 8'h9C;
    @(negedge clk);
    reg_addr = 5'd0; reg_rd = 1'b1;
    #1 check("R12 buffer data", {8'h00, reg_rdata}, 16'h009C);
    check("R12 buf_rd_o", {15'd0, buf_rd_o}, 16'd1);
    reg_rd = 1'b0; reg_wr = 1'b1;
    #1 check("R12 buf_wr_o", {15'd0, buf_wr_o}, 16'd1);
    reg_wr = 1'b0; reg_addr = 5'd4; reg_rd = 1'b1;
    #1 check("R12 no strobe elsewhere", {14'd0, buf_rd_o, buf_wr_o}, 16'd0);
    reg_rd = 1'b0;
  endtask

  task automatic t_status;
    buf_full_i = 1'b1; buf_avail_i = 1'b1;
    rd_chk("R4 buffer bits", 5'd8, 8'h30);
    pulse(2);
    rd_chk("R4 error bit", 5'd8, 8'h34);
    rd_chk("R6 error bit", 5'd9, 8'h41);
    wr(5'd8, 8'hFF);
    rd_chk("R4 clear mask keeps bit 2", 5'd8, 8'h34);
    wr(5'd9, 8'h01);
    rd_chk("R6 clear bit 0", 5'd9, 8'h40);
    bus_busy_i = 1'b1;
    rd_chk("R6 busy code", 5'd9, 8'h50);
    bus_busy_i = 1'b0; buf_full_i = 1'b0; buf_avail_i = 1'b0;
  endtask

  task automatic t_irq;
    wr(5'd7, 8'h04); wr(5'd13, 8'h01);
    pulse(1); check("R8 halt masked", {15'd0, irq_o}, 16'd0);
    pulse(0); check("R8 done fires", {15'd0, irq_o}, 16'd1);
    rd_chk("R8 status bit 1", 5'd8, 8'h06);
    wr(5'd8, 8'h02); check("R5 clear with enable", {15'd0, irq_o}, 16'd0);
    rd_chk("R4 bit 1 cleared", 5'd8, 8'h04);
    wr(5'd13, 8'h08);
    pulse(1); check("R8 halt fires", {15'd0, irq_o}, 16'd1);
    wr(5'd7, 8'h00); wr(5'd8, 8'h02);
    check("R5 clear without enable keeps irq", {15'd0, irq_o}, 16'd1);
    rd_chk("R4 bit 1 cleared anyway", 5'd8, 8'h04);
    wr(5'd7, 8'h04); wr(5'd8, 8'h02);
    check("R5 clear after enable", {15'd0, irq_o}, 16'd0);
    wr(5'd7, 8'h00); wr(5'd13, 8'h09);
    pulse(0); check("R8 no fire without enable", {15'd0, irq_o}, 16'd0);
    rd_chk("R8 no flag without enable", 5'd8, 8'h04);
  endtask

  task automatic t_collide;
    wr(5'd7, 8'h04); wr(5'd13, 8'h01);
    @(negedge clk);
    reg_addr = 5'd8; reg_wdata = 8'h02; reg_wr = 1'b1; evt_done_i = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0; evt_done_i = 1'b0;
    check("R9 set wins irq", {15'd0, irq_o}, 16'd1);
    rd_chk("R9 set wins flag", 5'd8, 8'h06);
    wr(5'd8, 8'h02); check("R9 later clear", {15'd0, irq_o}, 16'd0);
  endtask

  task automatic t_soft;
    wr(5'd4, 8'h12); wr(5'd5, 8'h34); wr(5'd10, 8'h56); wr(5'd11, 8'h78);
    wr(5'd12, 8'h99);
    pulse(0); check("R10 irq before soft reset", {15'd0, irq_o}, 16'd1);
    wr(5'd15, 8'h01);
    check("R10 irq low", {15'd0, irq_o}, 16'd0);
    rd_chk("R10 mode", 5'd7, 8'h00);
    rd_chk("R10 status", 5'd8, 8'h00);
    rd_chk("R10 xstatus", 5'd9, 8'h40);
    rd_chk("R10 clkdiv", 5'd12, 8'h00);
    rd_chk("R10 imask", 5'd13, 8'h00);
    rd_chk("R10 direct", 5'd16, 8'h0F);
    wr(5'd15, 8'hF0);
    rd_chk("R10 xctl clear", 5'd15, 8'h00);
    rd_chk("R2 madr lo soft", 5'd4, 8'h12);
    rd_chk("R2 sadr lo soft", 5'd10, 8'h56);
    check("R2 madr_o", madr_o, 16'h3412);
    wr(5'd7, 8'h3D);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd_chk("R2 madr hi hard", 5'd5, 8'h34);
    rd_chk("R2 sadr hi hard", 5'd11, 8'h78);
    rd_chk("R1 mode after hard reset", 5'd7, 8'h00);
  endtask

  task automatic t_gaps;
    rd_chk("R11 off 1", 5'd1, 8'h00);
    rd_chk("R11 off 2", 5'd2, 8'h00);
    rd_chk("R11 off 3", 5'd3, 8'h00);
    rd_chk("R11 off 17", 5'd17, 8'h00);
    rd_chk("R11 off 31", 5'd31, 8'h00);
    wr(5'd7, 8'h04);
    wr(5'd2, 8'hFF); wr(5'd17, 8'h00); wr(5'd3, 8'h00); wr(5'd31, 8'hFF);
    rd_chk("R11 mode untouched", 5'd7, 8'h04);
    rd_chk("R11 direct untouched", 5'd16, 8'h0F);
    rd_chk("R11 madr untouched", 5'd4, 8'h12);
    check("R11 irq untouched", {15'd0, irq_o}, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_masks();
    t_buffer();
    t_status();
    t_irq();
    t_collide();
    t_soft();
    t_gaps();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule